// File: doc/BRIEF.md
# Sliding-Window Idle Slot Enforcer

This block sits on the access path between user logic and a multi-banked embedded DRAM. Every clock cycle is one timeslot. The refresh scheduler can refresh only in a slot that it can use: either the user issues nothing, or the bank the scheduler wants is not the bank being accessed. The enforcer makes sure that every run of `SLOTS_Y` consecutive slots contains at least `MIN_FREE_X` usable slots. This holds for a run that starts at any cycle, not only for runs aligned to a fixed frame. To meet the rule it withholds `in_ready` from the user, and it does so only in a slot where a user access would break the rule.

The user side is a valid/ready handshake. The user raises `in_valid` and must keep it high until it sees `in_ready`. The access goes to the memory in the cycle in which both are high, and `mem_issue` marks that cycle. The scheduler drives `no_conflict` in the same slot. When `no_conflict` is high, the slot counts as usable whatever the user does. A slot that the block stalls is idle, so it also counts as usable. `win_usable` reports how many of the last `SLOTS_Y` completed slots were usable. The refresh overhead is `MIN_FREE_X/SLOTS_Y`. The user can make at most `SLOTS_Y - MIN_FREE_X` accesses in a row that the scheduler cannot use.

Top module: `idle_slot_enforcer`

## Requirements
- R1: While reset is held and in the first cycle after it, `win_usable` equals `SLOTS_Y` and `in_ready` is 1, because all slot history is treated as usable.
- R2: `win_usable` never drops below `MIN_FREE_X`. Every window of `SLOTS_Y` consecutive slots holds at least `MIN_FREE_X` usable slots.
- R3: `in_ready` is 0 in exactly those slots where `no_conflict` is 0 and the last `SLOTS_Y-1` completed slots hold fewer than `MIN_FREE_X` usable slots. In every other slot it is 1.
- R4: A slot with `no_conflict`=1 counts as usable, even when an access is issued in it.
- R5: A slot with `in_valid`=0 counts as usable, and so does a slot in which a request is stalled.
- R6: After reset, with `no_conflict` held at 0 and `in_valid` held at 1, the first `SLOTS_Y-MIN_FREE_X` requests are granted back to back and the next slot is stalled.
- R7: No run of consecutive slots that each issue an access with `no_conflict`=0 is longer than `SLOTS_Y-MIN_FREE_X`.
- R8: `win_usable` is registered. One cycle after a slot, it equals the number of usable slots among the last `SLOTS_Y` completed slots, that slot included.
- R9: `mem_issue` is 1 exactly when `in_valid` and `in_ready` are both 1. A stalled request that stays valid is issued in the first slot that grants it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one timeslot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | User has an access for this slot |
| in_ready | output | 1 | Grant. When 0 the slot is forced idle |
| no_conflict | input | 1 | Scheduler's target bank is not the bank accessed in this slot |
| mem_issue | output | 1 | Access goes to the memory in this slot |
| win_usable | output | $clog2(SLOTS_Y+1) | Usable slots among the last SLOTS_Y completed slots |

## Verification
Suppose the history or the running count goes wrong, for example a flag is dropped or a count step is off by one. `win_usable` then differs from a count made independently over the slot sequence, and it does so in the very next cycle. Suppose instead the grant rule goes wrong. A late stall appears as a run of unusable slots longer than `SLOTS_Y-MIN_FREE_X`. An early stall appears as `in_ready` low in a slot where the reference history still has enough usable slots. Either way the fault shows within one window of `SLOTS_Y` slots of continuous requests.

// File: rtl/idle_slot_pkg.sv
package idle_slot_pkg;

  typedef enum logic [1:0] {
    SLOT_IDLE   = 2'd0,
    SLOT_FORCED = 2'd1,
    SLOT_SHARED = 2'd2,
    SLOT_BUSY   = 2'd3
  } slot_kind_t;

  function automatic logic kind_is_usable(input slot_kind_t k);
    return k != SLOT_BUSY;
  endfunction

endpackage

// File: rtl/slot_history.sv
module slot_history #(
  parameter int DEPTH = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             usable_in,
  output logic [DEPTH-1:0] flags,
  output logic             oldest
);

  logic [DEPTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q[0] <= 1'b1;
    else        stage_q[0] <= usable_in;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[g] <= 1'b1;
      else        stage_q[g] <= stage_q[g-1];
    end
  end

  assign flags  = stage_q;
  assign oldest = stage_q[DEPTH-1];

endmodule

// File: rtl/window_counter.sv
module window_counter #(
  parameter int SLOTS_Y    = 26,
  parameter int MIN_FREE_X = 1,
  localparam int CW = $clog2(SLOTS_Y + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          usable_in,
  input  logic          oldest,
  output logic [CW-1:0] win_cnt,
  output logic [CW-1:0] tail_cnt
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= CW'(SLOTS_Y);
    else        cnt_q <= cnt_q + CW'(usable_in) - CW'(oldest);
  end

  assign win_cnt  = cnt_q;
  assign tail_cnt = cnt_q - CW'(oldest);

  assert_min_usable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= CW'(MIN_FREE_X)) && (cnt_q <= CW'(SLOTS_Y)));

endmodule

// File: rtl/grant_gate.sv
module grant_gate
  import idle_slot_pkg::*;
#(
  parameter int SLOTS_Y    = 26,
  parameter int MIN_FREE_X = 1,
  localparam int CW = $clog2(SLOTS_Y + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          no_conflict,
  input  logic [CW-1:0] tail_cnt,
  output logic          in_ready,
  output logic          issue,
  output logic          usable
);

  slot_kind_t kind;
  logic       room;

  assign room     = tail_cnt >= CW'(MIN_FREE_X);
  assign in_ready = no_conflict | room;
  assign issue    = in_valid & in_ready;

  always_comb begin
    if (!in_valid)        kind = SLOT_IDLE;
    else if (no_conflict) kind = SLOT_SHARED;
    else if (!room)       kind = SLOT_FORCED;
    else                  kind = SLOT_BUSY;
  end

  assign usable = kind_is_usable(kind);

  logic [CW-1:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                                run_q <= '0;
    else if (issue && !no_conflict)            run_q <= (run_q == CW'(SLOTS_Y)) ? run_q : run_q + 1'b1;
    else                                       run_q <= '0;
  end

  assert_busy_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= CW'(SLOTS_Y - MIN_FREE_X));

endmodule

// File: rtl/idle_slot_enforcer.sv
module idle_slot_enforcer #(
  parameter int SLOTS_Y    = 26,
  parameter int MIN_FREE_X = 1,
  localparam int CW = $clog2(SLOTS_Y + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          no_conflict,
  output logic          mem_issue,
  output logic [CW-1:0] win_usable
);

  logic               usable;
  logic               oldest;
  logic [SLOTS_Y-1:0] flags;
  logic [CW-1:0]      tail_cnt;
  logic [CW-1:0]      win_cnt;

  grant_gate #(.SLOTS_Y(SLOTS_Y), .MIN_FREE_X(MIN_FREE_X)) u_gate (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .no_conflict(no_conflict),
    .tail_cnt(tail_cnt), .in_ready(in_ready), .issue(mem_issue), .usable(usable)
  );

  slot_history #(.DEPTH(SLOTS_Y)) u_hist (
    .clk(clk), .rst_n(rst_n), .usable_in(usable), .flags(flags), .oldest(oldest)
  );

  window_counter #(.SLOTS_Y(SLOTS_Y), .MIN_FREE_X(MIN_FREE_X)) u_cnt (
    .clk(clk), .rst_n(rst_n), .usable_in(usable), .oldest(oldest),
    .win_cnt(win_cnt), .tail_cnt(tail_cnt)
  );

  assign win_usable = win_cnt;

  assert_cnt_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt == CW'($countones(flags)));

  assert_shared_usable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    no_conflict |=> win_cnt == $past(tail_cnt) + 1'b1);

  assert_idle_usable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> win_cnt == $past(tail_cnt) + 1'b1);

  assert_stall_resolves_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> win_cnt == $past(tail_cnt) + 1'b1);

endmodule

// File: tb/tb_idle_slot_enforcer.sv
module tb_idle_slot_enforcer;
  localparam int Y  = 26;
  localparam int X  = 1;
  localparam int CW = $clog2(Y + 1);

  logic clk = 0, rst_n = 0, in_valid = 0, no_conflict = 0;
  logic in_ready, mem_issue;
  logic [CW-1:0] win_usable;

  idle_slot_enforcer #(.SLOTS_Y(Y), .MIN_FREE_X(X)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .no_conflict(no_conflict), .mem_issue(mem_issue), .win_usable(win_usable)
  );

  always #10 clk = ~clk;

  int compared = 0, mismatched = 0, run = 0;
  bit done = 0;
  bit model [Y];
  bit last_acc;

  function automatic int sum_first(input int n);
    int s = 0;
    for (int i = 0; i < n; i++) s += model[i];
    return s;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < Y; i++) model[i] = 1;
    run = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; in_valid = 0; no_conflict = 0;
    repeat (2) @(negedge clk);
    check("R1 win_usable in reset", win_usable, Y);
    rst_n = 1;
    model_reset();
  endtask

  task automatic slot(input bit v, input bit n);
    bit er, u;
    @(negedge clk); in_valid = v; no_conflict = n; #2;
    er = (sum_first(Y - 1) >= X) || n;
    check("R3 in_ready", in_ready, er);
    check("R9 mem_issue", mem_issue, v && er);
    check("R8 win_usable", win_usable, sum_first(Y));
    u = !(v && er) || n;
    for (int i = Y - 1; i > 0; i--) model[i] = model[i-1];
    model[0] = u;
    if (v && er && !n) run++; else run = 0;
    check("R7 busy run bound", run <= Y - X, 1);
    last_acc = v && er;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int grants;
    bit pend, v, n;
    void'($urandom(32'h5EED1234));
    do_reset();
    @(negedge clk); #2;
    check("R1 ready after reset", in_ready, 1);
    check("R1 win_usable after reset", win_usable, Y);

    // R6: back-to-back burst from reset
    grants = 0;
    for (int i = 0; i < Y - X; i++) begin slot(1, 0); grants += last_acc; end
    check("R6 grants before stall", grants, Y - X);
    slot(1, 0);
    check("R6 stall after burst", last_acc, 0);
    // R4: conflict-free slot granted while deficit persists
    for (int i = 0; i < 5; i++) slot(1, 0);
    slot(1, 1);
    check("R4 shared slot granted", last_acc, 1);
    // R5: idle slots refill the window
    for (int i = 0; i < Y; i++) slot(0, 0);
    check("R5 idle refill", win_usable, Y);

    // random phases with varying density
    for (int ph = 0; ph < 6; ph++) begin
      int pv = 40 + ph * 12, pn = 40 - ph * 7;
      do_reset();
      pend = 0;
      for (int i = 0; i < 2000; i++) begin
        v = pend || (($urandom % 100) < pv);
        n = ($urandom % 100) < pn;
        slot(v, n);
        pend = v && !last_acc;
      end
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule